// File: doc/BRIEF.md
# Trim Command Decoder with Write Protect

This block turns a stream of 16-bit trim commands into actions on twelve 8-bit DAC code registers and on an external nonvolatile store. A command can set a channel code directly, restore one channel or all channels from one of four storage banks, program a byte into storage, read a byte back out, or open and close a write-protect latch. The DAC code registers are the block's output. An analog converter or trim network downstream turns each code into a level, with 00h as the minimum and FFh as full scale.

Commands enter on a valid/ready interface. `cmd_ready` is low while a recall or a read-back is in flight, and a command is taken in the cycle where `cmd_valid` and `cmd_ready` are both high. A command that is taken while the store reports busy is consumed and has no effect. Bytes read back leave on a second valid/ready interface. `rd_valid` and `rd_data` hold until `rd_ready` is seen, and no new command is taken until the byte has left.

The storage side is a plain request port. A one-cycle `mem_req` carries `mem_we`, bank, channel and write data. For a read, the store answers later with a one-cycle `mem_rvalid` and `mem_rdata`. A `preset_load` pulse restores every channel from the bank on the `ext_bank` pins and closes the write latch.

Top module: `trim_cmd_decoder`

## Requirements
- R1: Command word fields: bits 15:14 bank, bits 13:12 opcode, bits 11:8 channel (1 to 12 name channels 1 to 12, and channel k sits in `dac_out[8k-1:8k-8]`), bits 7:0 data. Opcode 00 with channel 1..12 sets that channel's code to the data field on the edge that takes the command.
- R2: Opcode 00 or 01 with channel 0, 13, 14 or 15, and opcode 10 or 11 with channel 13 or 14, change no DAC code, issue no storage request and produce no read-back byte.
- R3: Opcode 10 with channel 1..12 issues one storage read for that bank and channel. The returned byte becomes that channel's code.
- R4: Opcode 10 with channel 0 reads channels 1 to 12 of the bank in ascending order, one read outstanding at a time, and loads each returned byte into its channel.
- R5: Opcode 11 with channel 0 sets the write latch. Opcode 11 with channel 15 clears it.
- R6: Opcode 01 with channel 1..12 issues a storage write of the data field to that bank and channel one cycle after acceptance, only while the write latch is set. With the latch clear, the command is dropped.
- R7: The write latch is clear after reset. A `preset_load` pulse while idle clears it and restores all twelve channels from bank `ext_bank`.
- R8: With `sel` high the bank comes from bits 15:14 of the command. With `sel` low it comes from `ext_bank`.
- R9: Opcode 11 with channel 1..12 reads that storage byte and presents it on `rd_data` with `rd_valid`, held stable until `rd_ready` is high.
- R10: A command accepted while `mem_busy` is high has no effect, including on the write latch.
- R11: After reset every DAC code is 00h, `cmd_ready` is high and `rd_valid` is low.
- R12: `cmd_ready` is low from the edge that takes a recall or read-back command until that operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Bank source: 1 = command field, 0 = `ext_bank` |
| ext_bank | input | 2 | Bank pins |
| preset_load | input | 1 | Restore all channels from `ext_bank` and clear the write latch |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command ready |
| cmd_word | input | 16 | Command word |
| mem_req | output | 1 | One-cycle storage request |
| mem_we | output | 1 | Request is a write |
| mem_bank | output | 2 | Storage bank |
| mem_chan | output | 4 | Storage channel |
| mem_wdata | output | 8 | Write byte |
| mem_busy | input | 1 | Store busy with a program cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data |
| rd_valid | output | 1 | Read-back byte valid |
| rd_ready | input | 1 | Read-back byte taken |
| rd_data | output | 8 | Read-back byte |
| dac_out | output | 96 | Twelve 8-bit DAC codes |

## Verification
A write latch left in the wrong state does not appear on any pin until the next program command. That command then either raises `mem_req` with `mem_we` one cycle after acceptance or stays silent, so the bench probes the latch with program commands after each enable, disable, busy and preset event. A wrong sequencer state shows at once as `cmd_ready` staying low or dropping too early. A wrong recall address or order shows in the read request log and in the DAC codes a few cycles after the last read returns.

// File: rtl/trim_pkg.sv
package trim_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_LOAD, OP_RECALL, OP_RECALL_ALL, OP_PROG, OP_WEN, OP_WDIS, OP_FETCH
  } trim_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_REC_ONE, S_REC_ALL, S_FETCH, S_HOLD
  } trim_state_e;
endpackage

// File: rtl/trim_cmd_decode.sv
module trim_cmd_decode #(
  parameter int NUM_CH = 12,
  parameter int CHW    = 4
) (
  input  logic            op_hi,
  input  logic            op_lo,
  input  logic [CHW-1:0]  chan,
  output trim_pkg::trim_op_e op
);
  import trim_pkg::*;
  logic in_range;
  assign in_range = (chan != '0) && (chan <= CHW'(NUM_CH));

  always_comb begin
    op = OP_NONE;
    case ({op_hi, op_lo})
      2'b00: if (in_range) op = OP_LOAD;
      2'b10: begin
        if (chan == '0) op = OP_RECALL_ALL;
        else if (in_range) op = OP_RECALL;
      end
      2'b01: if (in_range) op = OP_PROG;
      default: begin
        if (chan == '0) op = OP_WEN;
        else if (chan == '1) op = OP_WDIS;
        else if (in_range) op = OP_FETCH;
      end
    endcase
  end
endmodule

// File: rtl/trim_dac_regs.sv
module trim_dac_regs #(
  parameter int NUM_CH = 12,
  parameter int DW     = 8,
  parameter int CHW    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [CHW-1:0]       wr_chan,
  input  logic [DW-1:0]        wr_data,
  output logic [NUM_CH*DW-1:0] codes
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [DW-1:0] code_q;
    always_ff @(posedge clk) begin
      if (!rst_n) code_q <= '0;
      else if (wr_en && wr_chan == CHW'(g + 1)) code_q <= wr_data;
    end
    assign codes[g*DW +: DW] = code_q;
  end
endmodule

// File: rtl/trim_wen_latch.sv
module trim_wen_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else if (clr_i) q <= 1'b0;
    else if (set_i) q <= 1'b1;
  end
endmodule

// File: rtl/trim_cmd_decoder.sv
module trim_cmd_decoder #(
  parameter int NUM_CH = 12,
  parameter int DW     = 8,
  parameter int CHW    = 4,
  parameter int BANKW  = 2,
  localparam int CMDW  = BANKW + 2 + CHW + DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel,
  input  logic [BANKW-1:0]     ext_bank,
  input  logic                 preset_load,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [CMDW-1:0]      cmd_word,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [BANKW-1:0]     mem_bank,
  output logic [CHW-1:0]       mem_chan,
  output logic [DW-1:0]        mem_wdata,
  input  logic                 mem_busy,
  input  logic                 mem_rvalid,
  input  logic [DW-1:0]        mem_rdata,
  output logic                 rd_valid,
  input  logic                 rd_ready,
  output logic [DW-1:0]        rd_data,
  output logic [NUM_CH*DW-1:0] dac_out
);
  import trim_pkg::*;

  trim_state_e     state;
  trim_op_e        op;
  logic            seq_idle, accept, live, preset_go, wen_q;
  logic [BANKW-1:0] f_bank, use_bank;
  logic [CHW-1:0]  f_chan;
  logic [DW-1:0]   f_data;
  logic            dac_we;
  logic [CHW-1:0]  dac_chan;
  logic [DW-1:0]   dac_data;

  assign f_bank    = cmd_word[CMDW-1 -: BANKW];
  assign f_chan    = cmd_word[DW +: CHW];
  assign f_data    = cmd_word[DW-1:0];
  assign use_bank  = sel ? f_bank : ext_bank;

  assign seq_idle  = (state == S_IDLE);
  assign cmd_ready = seq_idle && !preset_load;
  assign accept    = cmd_valid && cmd_ready;
  assign live      = accept && !mem_busy;
  assign preset_go = preset_load && seq_idle;

  trim_cmd_decode #(.NUM_CH(NUM_CH), .CHW(CHW)) u_dec (
    .op_hi(cmd_word[CHW+DW+1]), .op_lo(cmd_word[CHW+DW]), .chan(f_chan), .op(op)
  );

  trim_wen_latch u_wen (
    .clk(clk), .rst_n(rst_n),
    .set_i(live && op == OP_WEN),
    .clr_i(preset_go || (live && op == OP_WDIS)),
    .q(wen_q)
  );

  always_comb begin
    if (live && op == OP_LOAD) begin
      dac_we = 1'b1; dac_chan = f_chan; dac_data = f_data;
    end else begin
      dac_we   = mem_rvalid && (state == S_REC_ONE || state == S_REC_ALL);
      dac_chan = mem_chan;
      dac_data = mem_rdata;
    end
  end

  trim_dac_regs #(.NUM_CH(NUM_CH), .DW(DW), .CHW(CHW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(dac_we), .wr_chan(dac_chan),
    .wr_data(dac_data), .codes(dac_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_bank  <= '0;
      mem_chan  <= '0;
      mem_wdata <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
      case (state)
        S_IDLE: begin
          if (preset_go) begin
            mem_req  <= 1'b1;
            mem_bank <= ext_bank;
            mem_chan <= CHW'(1);
            state    <= S_REC_ALL;
          end else if (live) begin
            case (op)
              OP_RECALL: begin
                mem_req <= 1'b1; mem_bank <= use_bank; mem_chan <= f_chan;
                state   <= S_REC_ONE;
              end
              OP_RECALL_ALL: begin
                mem_req <= 1'b1; mem_bank <= use_bank; mem_chan <= CHW'(1);
                state   <= S_REC_ALL;
              end
              OP_PROG: if (wen_q) begin
                mem_req <= 1'b1; mem_we <= 1'b1; mem_bank <= use_bank;
                mem_chan <= f_chan; mem_wdata <= f_data;
              end
              OP_FETCH: begin
                mem_req <= 1'b1; mem_bank <= use_bank; mem_chan <= f_chan;
                state   <= S_FETCH;
              end
              default: ;
            endcase
          end
        end
        S_REC_ONE: if (mem_rvalid) state <= S_IDLE;
        S_REC_ALL: if (mem_rvalid) begin
          if (mem_chan == CHW'(NUM_CH)) state <= S_IDLE;
          else begin
            mem_req  <= 1'b1;
            mem_chan <= mem_chan + 1'b1;
          end
        end
        S_FETCH: if (mem_rvalid) begin
          rd_data  <= mem_rdata;
          rd_valid <= 1'b1;
          state    <= S_HOLD;
        end
        S_HOLD: if (rd_ready) begin
          rd_valid <= 1'b0;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trim_cmd_decoder_chk.sv
module trim_cmd_decoder_chk #(
  parameter int NUM_CH = 12,
  parameter int DW     = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_valid,
  input logic                 cmd_ready,
  input logic                 preset_load,
  input logic                 seq_idle,
  input logic                 mem_busy,
  input logic                 mem_req,
  input logic                 mem_we,
  input logic                 wen_q,
  input logic                 rd_valid,
  input logic                 rd_ready,
  input logic [DW-1:0]        rd_data,
  input logic [NUM_CH*DW-1:0] dac_out
);
  p_prog_needs_wen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> wen_q);

  p_req_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  p_busy_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && mem_busy |=> !mem_req && $stable(dac_out));

  p_preset_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    preset_load && seq_idle |=> !wen_q);
endmodule

bind trim_cmd_decoder trim_cmd_decoder_chk #(.NUM_CH(NUM_CH), .DW(DW)) u_chk (.*);

// File: tb/tb_trim_cmd_decoder.sv
module tb_trim_cmd_decoder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, sel = 1'b1, preset_load = 1'b0;
  logic [1:0] ext_bank = 2'd0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [15:0] cmd_word = '0;
  logic mem_req, mem_we, mem_busy, mem_rvalid = 1'b0, rd_valid, rd_ready = 1'b1;
  logic [1:0] mem_bank;
  logic [3:0] mem_chan;
  logic [7:0] mem_wdata, mem_rdata = '0, rd_data;
  logic [95:0] dac_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  trim_cmd_decoder dut (.*);

  // storage model
  logic [7:0] mem [4][16];
  int busy_cnt = 0, wr_count = 0, rd_cnt = 0, pend = 0;
  logic force_busy = 1'b0;
  logic [1:0] pb, lw_bank;
  logic [3:0] pc, lw_chan;
  logic [7:0] lw_data;
  logic [3:0] rd_log_chan [32];
  logic [1:0] rd_log_bank [32];
  assign mem_busy = (busy_cnt != 0) || force_busy;

  function automatic logic [7:0] seed(int b, int c);
    return 8'(b * 53 + c * 29 + 17);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 16; c++) mem[b][c] <= seed(b, c);
    end
    mem_rvalid <= 1'b0;
    if (mem_req && mem_we) begin
      mem[mem_bank][mem_chan] <= mem_wdata;
      wr_count <= wr_count + 1;
      lw_bank <= mem_bank; lw_chan <= mem_chan; lw_data <= mem_wdata;
      busy_cnt <= 6;
    end else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    if (mem_req && !mem_we) begin
      pend <= 2; pb <= mem_bank; pc <= mem_chan;
      rd_log_chan[rd_cnt[4:0]] <= mem_chan;
      rd_log_bank[rd_cnt[4:0]] <= mem_bank;
      rd_cnt <= rd_cnt + 1;
    end else if (pend != 0) begin
      pend <= pend - 1;
      if (pend == 1) begin mem_rvalid <= 1'b1; mem_rdata <= mem[pb][pc]; end
    end
  end

  int errors = 0, checks = 0, cyc = 0;
  logic [7:0] exp_dac [1:12];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 60000) begin
      errors = errors + 1;
      $display("FAIL watchdog: act=%0d exp=<60000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic chk_dac(string req);
    for (int k = 1; k <= 12; k++) chk(req, dac_out[k*8-1 -: 8], exp_dac[k]);
  endtask

  function automatic logic [15:0] mk(int bank, int op, int ch, int d);
    return {2'(bank), 2'(op), 4'(ch), 8'(d)};
  endfunction

  task automatic send(logic [15:0] w);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_word = w;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!cmd_ready || rd_valid || mem_busy || pend != 0) @(negedge clk);
  endtask

  task automatic t_reset();
    for (int k = 1; k <= 12; k++) exp_dac[k] = 8'h00;
    chk_dac("R11 reset code");
    chk("R11 ready", cmd_ready, 1);
    chk("R11 rd_valid", rd_valid, 0);
  endtask

  task automatic t_load();
    send(mk(0, 0, 1, 8'hA5));  exp_dac[1]  = 8'hA5;
    chk("R1 load visible next cycle", dac_out[7:0], 8'hA5);
    send(mk(2, 0, 12, 8'hFF)); exp_dac[12] = 8'hFF;
    send(mk(1, 0, 7, 8'h3C));  exp_dac[7]  = 8'h3C;
    send(mk(1, 0, 7, 8'h00));  exp_dac[7]  = 8'h00;
    chk_dac("R1 load");
  endtask

  task automatic t_ignored();
    int rc = rd_cnt, wc = wr_count;
    send(mk(0, 0, 0, 8'h5A));  send(mk(0, 0, 13, 8'h5A));
    send(mk(0, 0, 14, 8'h5A)); send(mk(0, 0, 15, 8'h5A));
    send(mk(0, 2, 13, 0));     send(mk(0, 3, 14, 0));
    send(mk(0, 2, 14, 0));     send(mk(0, 3, 13, 0));
    send(mk(0, 1, 0, 8'h5A));  send(mk(0, 1, 15, 8'h5A));
    repeat (4) @(negedge clk);
    chk_dac("R2 ignored codes");
    chk("R2 no reads", rd_cnt, rc);
    chk("R2 no writes", wr_count, wc);
    chk("R2 no read-back", rd_valid, 0);
  endtask

  task automatic t_write();
    int wc = wr_count;
    send(mk(1, 1, 2, 8'h77));
    repeat (3) @(negedge clk);
    chk("R7 R6 latch clear after reset drops write", wr_count, wc);
    send(mk(0, 3, 0, 0));
    send(mk(1, 1, 2, 8'h77));
    chk("R6 write request one cycle after accept", {mem_req, mem_we}, 2'b11);
    @(negedge clk);
    chk("R5 R6 write issued", wr_count, wc + 1);
    chk("R6 write fields", {lw_bank, lw_chan, lw_data}, {2'd1, 4'd2, 8'h77});
    wait_idle();
    send(mk(0, 3, 15, 0));
    send(mk(1, 1, 3, 8'h11));
    repeat (3) @(negedge clk);
    chk("R5 disable blocks write", wr_count, wc + 1);
  endtask

  task automatic t_recall_one();
    send(mk(1, 2, 2, 0));
    chk("R12 ready low during recall", cmd_ready, 0);
    wait_idle(); exp_dac[2] = 8'h77;
    chk_dac("R3 single recall");
    sel = 1'b0; ext_bank = 2'd2;
    send(mk(1, 2, 5, 0));
    wait_idle(); exp_dac[5] = seed(2, 5);
    chk("R8 bank from pins", rd_log_bank[(rd_cnt - 1) % 32], 2);
    chk_dac("R8 recall via pins");
    sel = 1'b1;
  endtask

  task automatic t_recall_all();
    int rc = rd_cnt;
    send(mk(3, 2, 0, 0));
    chk("R12 ready low during all-recall", cmd_ready, 0);
    wait_idle();
    chk("R4 twelve reads", rd_cnt - rc, 12);
    for (int k = 1; k <= 12; k++) begin
      chk("R4 read order", rd_log_chan[(rc + k - 1) % 32], k);
      exp_dac[k] = seed(3, k);
    end
    chk_dac("R4 all-recall codes");
  endtask

  task automatic t_fetch();
    logic [7:0] keep1 = exp_dac[2];
    rd_ready = 1'b0;
    send(mk(1, 3, 2, 0));
    while (!rd_valid) @(negedge clk);
    chk("R9 read-back data", rd_data, 8'h77);
    repeat (3) @(negedge clk);
    chk("R9 held without ready", {rd_valid, rd_data}, {1'b1, 8'h77});
    chk("R12 ready low while byte pending", cmd_ready, 0);
    rd_ready = 1'b1;
    @(negedge clk);
    chk("R9 valid drops after ready", rd_valid, 0);
    chk("R9 no code change", dac_out[15:8], keep1);
  endtask

  task automatic t_busy();
    int wc = wr_count, rc = rd_cnt;
    force_busy = 1'b1;
    send(mk(0, 0, 1, 8'h11));
    send(mk(0, 2, 0, 0));
    send(mk(0, 3, 0, 0));
    repeat (2) @(negedge clk);
    chk_dac("R10 busy load dropped");
    chk("R10 busy recall dropped", rd_cnt, rc);
    force_busy = 1'b0;
    send(mk(0, 1, 4, 8'h22));
    repeat (3) @(negedge clk);
    chk("R10 busy enable dropped", wr_count, wc);
  endtask

  task automatic t_preset();
    int wc;
    send(mk(0, 3, 0, 0));
    wait_idle();
    ext_bank = 2'd0;
    preset_load = 1'b1;
    @(negedge clk);
    preset_load = 1'b0;
    wait_idle();
    for (int k = 1; k <= 12; k++) exp_dac[k] = seed(0, k);
    chk_dac("R7 preset restore");
    wc = wr_count;
    send(mk(0, 1, 1, 8'h99));
    repeat (3) @(negedge clk);
    chk("R7 preset clears latch", wr_count, wc);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_ignored();
    t_write();
    t_recall_one();
    t_recall_all();
    t_fetch();
    t_busy();
    t_preset();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule